// File: doc/BRIEF.md
# Programmable Field Sync Timing Adjuster

This block moves two vertical timing events in an interlaced 625-line video timing stream. The first is the line on which the vertical sync pulse ends. The second is the line on which the field flag toggles. An upstream line counter supplies three inputs: a strobe at the start of every line, a strobe at every mid-line point, and a field-start marker together with the parity of the field that is starting. The block counts half-line positions inside the field. It keeps one half-line counter for the whole block.

Each event has its own settings: a 5-bit line count, a direction bit (delay or advance), and an extra one-line delay that is chosen separately for odd and even fields. The sync end can also be pulled earlier by half a line, again chosen separately per field. The settings and the parity are captured at each field start, so a new setting takes effect from the next field. Each event position is reduced modulo the field length, so an advance can wrap around to the end of the field.

One flop drives both the sync pin output and the V bit of the embedded timing code, so the two always move together. Another flop drives both the FIELD output and the F bit.

The sync output is built from a two-state machine with states `VS_LOW` and `VS_HIGH`:
- Transition *assert* (`VS_LOW`→`VS_HIGH`) fires on a strobe that lands on the fixed rise position.
- Transition *release* (`VS_HIGH`→`VS_LOW`) fires on a strobe that lands on the adjusted end position.

The field flag is built from a second two-state machine with states `FLD_LO` and `FLD_HI`:
- Transition *toggle* moves it to the other state on a strobe that lands on the adjusted toggle position.

Top module: `field_sync_adj`

## Requirements
- R1: During and straight after reset, `vs_o`, `vbit_o`, `field_o` and `fbit_o` are all 0.
- R2: Half-line positions are numbered as follows. A line strobe with `field_start_i` set moves the position to 0. Every other line or half-line strobe adds 1, and the position wraps from FIELD_HALVES-1 to 0. VS goes high on the strobe that moves the position to VS_RISE_H.
- R3: When `vend_adv_i`=0, VS goes low on the strobe that reaches half-line position 2·VEND_REF_LINE + 2·count + 2·extra − half (mod FIELD_HALVES). Here count is `vend_cnt_i`, extra is the selected one-line delay bit and half is the selected half-line advance bit.
- R4: When `vend_adv_i`=1, the count is subtracted instead of added. A result below zero wraps modulo FIELD_HALVES to the end of the field.
- R5: The one-line extra delay for the sync end comes from `vend_xdly_odd_i` when the captured parity is odd (`field_odd_i`=1) and from `vend_xdly_even_i` otherwise.
- R6: The half-line advance comes from `vend_hadv_odd_i` or `vend_hadv_even_i` by the captured parity. It is applied on top of the line offset and the extra line.
- R7: FIELD toggles exactly once per field cycle. It toggles on the strobe that reaches 2·FTOG_REF_LINE ± 2·`ftog_cnt_i` + 2·extra (mod FIELD_HALVES). The sign is minus when `ftog_adv_i`=1. The extra bit is `ftog_xdly_odd_i` or `ftog_xdly_even_i`, chosen by the captured parity.
- R8: All settings and `field_odd_i` are captured only on a field-start line strobe. A change in the middle of a field leaves VS and FIELD timing unchanged until the next field start.
- R9: Outputs change only in the cycle that follows a line or half-line strobe. They never change after a cycle with no strobe.
- R10: `vbit_o` always equals `vs_o`, and `fbit_o` always equals `field_o`.
- R11: If the sync end position equals VS_RISE_H, the rise wins and VS is high after that strobe.
- R12: Until the first field start, the captured settings hold their reset values:
  - Sync end: count 20, delay, no extra lines, no half-line advance.
  - Field toggle: count 3, advance, odd extra 0, even extra 1.
  - Parity: even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_stb_i | input | 1 | Start-of-line strobe, one cycle |
| half_stb_i | input | 1 | Mid-line strobe, one cycle |
| field_start_i | input | 1 | Marks the line strobe that begins a field |
| field_odd_i | input | 1 | Parity of the starting field (1 = odd) |
| vend_cnt_i | input | 5 | Sync end line offset |
| vend_adv_i | input | 1 | Sync end direction: 0 delay, 1 advance |
| vend_xdly_odd_i | input | 1 | Extra line of sync end delay in odd fields |
| vend_xdly_even_i | input | 1 | Extra line of sync end delay in even fields |
| vend_hadv_odd_i | input | 1 | Half-line sync end advance in odd fields |
| vend_hadv_even_i | input | 1 | Half-line sync end advance in even fields |
| ftog_cnt_i | input | 5 | Field toggle line offset |
| ftog_adv_i | input | 1 | Field toggle direction: 0 delay, 1 advance |
| ftog_xdly_odd_i | input | 1 | Extra line of toggle delay in odd fields |
| ftog_xdly_even_i | input | 1 | Extra line of toggle delay in even fields |
| vs_o | output | 1 | Vertical sync output |
| field_o | output | 1 | Field flag output |
| vbit_o | output | 1 | V bit for embedded timing codes |
| fbit_o | output | 1 | F bit for embedded timing codes |

## Verification
The bench sweeps every line count from 0 to 31 for both directions, on odd and even fields alternately. This separates delay from advance and covers the wrap below zero that advances cause. It then walks every combination of the per-field extra-line bits and half-line bits. Because the fields alternate, a swapped odd/even selection shows up at once.

A free-running period before any field start shows whether the reset settings are in use. A run that changes the settings and the parity mid-field separates capture at field start from live use of the inputs. A sync end placed on the rise position confirms that the rise takes priority. Every cycle, including the idle cycle after each strobe, is compared against an arithmetic model. This catches outputs that change outside a strobe and V/F bits that drift from their pins.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    typedef struct packed {
        logic [4:0] cnt;
        logic       adv;
        logic       xdly_odd;
        logic       xdly_even;
        logic       hadv_odd;
        logic       hadv_even;
    } evt_cfg_t;

    localparam evt_cfg_t VEND_RST = '{cnt: 5'd20, adv: 1'b0, xdly_odd: 1'b0,
                                      xdly_even: 1'b0, hadv_odd: 1'b0, hadv_even: 1'b0};
    localparam evt_cfg_t FTOG_RST = '{cnt: 5'd3, adv: 1'b1, xdly_odd: 1'b0,
                                      xdly_even: 1'b1, hadv_odd: 1'b0, hadv_even: 1'b0};

    typedef enum logic {VS_LOW = 1'b0, VS_HIGH = 1'b1} vs_state_t;
    typedef enum logic {FLD_LO = 1'b0, FLD_HI = 1'b1} fld_state_t;

endpackage

// File: rtl/fsa_halfpos_ctr.sv
module fsa_halfpos_ctr #(
    parameter int FIELD_HALVES = 625,
    localparam int POS_W = $clog2(FIELD_HALVES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             restart_i,
    output logic [POS_W-1:0] pos_nxt_o,
    output logic [POS_W-1:0] pos_q_o
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FIELD_HALVES - 1);

    always_comb begin
        if (restart_i)
            pos_nxt_o = '0;
        else if (pos_q_o == LAST)
            pos_nxt_o = '0;
        else
            pos_nxt_o = pos_q_o + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pos_q_o <= '0;
        else if (step_i)
            pos_q_o <= pos_nxt_o;
    end
endmodule

// File: rtl/fsa_event_target.sv
module fsa_event_target #(
    parameter int FIELD_HALVES = 625,
    parameter int REF_H        = 0,
    localparam int POS_W = $clog2(FIELD_HALVES),
    localparam int TW    = POS_W + 2
) (
    input  logic [4:0]       cnt_i,
    input  logic             adv_i,
    input  logic             xdly_i,
    input  logic             hadv_i,
    output logic [POS_W-1:0] target_o
);
    // Bias by one field so an advance never goes below zero before reduction.
    localparam logic [TW-1:0] BASE = TW'(REF_H + FIELD_HALVES);
    localparam logic [TW-1:0] FH_V = TW'(FIELD_HALVES);

    logic [TW-1:0] off;
    logic [TW-1:0] raw;
    logic [TW-1:0] red1;
    logic [TW-1:0] red2;

    always_comb begin
        off  = TW'({cnt_i, 1'b0});
        raw  = adv_i ? (BASE - off) : (BASE + off);
        raw  = raw + (xdly_i ? TW'(2) : TW'(0)) - (hadv_i ? TW'(1) : TW'(0));
        red1 = (raw  >= FH_V) ? (raw  - FH_V) : raw;
        red2 = (red1 >= FH_V) ? (red1 - FH_V) : red1;
        target_o = red2[POS_W-1:0];
    end
endmodule

// File: rtl/field_sync_adj.sv
module field_sync_adj
    import fsa_pkg::*;
#(
    parameter int FIELD_HALVES  = 625,
    parameter int VS_RISE_H     = 0,
    parameter int VEND_REF_LINE = 4,
    parameter int FTOG_REF_LINE = 4,
    localparam int POS_W = $clog2(FIELD_HALVES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_stb_i,
    input  logic       half_stb_i,
    input  logic       field_start_i,
    input  logic       field_odd_i,
    input  logic [4:0] vend_cnt_i,
    input  logic       vend_adv_i,
    input  logic       vend_xdly_odd_i,
    input  logic       vend_xdly_even_i,
    input  logic       vend_hadv_odd_i,
    input  logic       vend_hadv_even_i,
    input  logic [4:0] ftog_cnt_i,
    input  logic       ftog_adv_i,
    input  logic       ftog_xdly_odd_i,
    input  logic       ftog_xdly_even_i,
    output logic       vs_o,
    output logic       field_o,
    output logic       vbit_o,
    output logic       fbit_o
);
    localparam logic [POS_W-1:0] RISE_POS = POS_W'(VS_RISE_H);

    logic             step;
    logic             restart;
    logic [POS_W-1:0] pos_nxt;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] vend_t;
    logic [POS_W-1:0] ftog_t;

    evt_cfg_t vend_live, ftog_live;
    evt_cfg_t vend_q,    ftog_q;
    evt_cfg_t vend_use,  ftog_use;
    logic     odd_q, odd_use;

    vs_state_t  vs_st,  vs_nx;
    fld_state_t fld_st, fld_nx;

    assign step    = line_stb_i | half_stb_i;
    assign restart = line_stb_i & field_start_i;

    always_comb begin
        vend_live = '{cnt: vend_cnt_i, adv: vend_adv_i, xdly_odd: vend_xdly_odd_i,
                      xdly_even: vend_xdly_even_i, hadv_odd: vend_hadv_odd_i,
                      hadv_even: vend_hadv_even_i};
        ftog_live = '{cnt: ftog_cnt_i, adv: ftog_adv_i, xdly_odd: ftog_xdly_odd_i,
                      xdly_even: ftog_xdly_even_i, hadv_odd: 1'b0, hadv_even: 1'b0};
        vend_use  = restart ? vend_live   : vend_q;
        ftog_use  = restart ? ftog_live   : ftog_q;
        odd_use   = restart ? field_odd_i : odd_q;
    end

    // Settings and parity are captured once per field.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vend_q <= VEND_RST;
            ftog_q <= FTOG_RST;
            odd_q  <= 1'b0;
        end else if (restart) begin
            vend_q <= vend_live;
            ftog_q <= ftog_live;
            odd_q  <= field_odd_i;
        end
    end

    fsa_halfpos_ctr #(.FIELD_HALVES(FIELD_HALVES)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .restart_i (restart),
        .pos_nxt_o (pos_nxt),
        .pos_q_o   (pos_q)
    );

    fsa_event_target #(.FIELD_HALVES(FIELD_HALVES), .REF_H(2 * VEND_REF_LINE)) u_vend (
        .cnt_i    (vend_use.cnt),
        .adv_i    (vend_use.adv),
        .xdly_i   (odd_use ? vend_use.xdly_odd : vend_use.xdly_even),
        .hadv_i   (odd_use ? vend_use.hadv_odd : vend_use.hadv_even),
        .target_o (vend_t)
    );

    fsa_event_target #(.FIELD_HALVES(FIELD_HALVES), .REF_H(2 * FTOG_REF_LINE)) u_ftog (
        .cnt_i    (ftog_use.cnt),
        .adv_i    (ftog_use.adv),
        .xdly_i   (odd_use ? ftog_use.xdly_odd : ftog_use.xdly_even),
        .hadv_i   (1'b0),
        .target_o (ftog_t)
    );

    // Next-state logic for both machines.
    always_comb begin
        vs_nx  = vs_st;
        fld_nx = fld_st;
        if (step) begin
            unique case (vs_st)
                VS_LOW:  if (pos_nxt == RISE_POS) vs_nx = VS_HIGH;
                VS_HIGH: if (pos_nxt == vend_t && pos_nxt != RISE_POS) vs_nx = VS_LOW;
                default: vs_nx = VS_LOW;
            endcase
            unique case (fld_st)
                FLD_LO:  if (pos_nxt == ftog_t) fld_nx = FLD_HI;
                FLD_HI:  if (pos_nxt == ftog_t) fld_nx = FLD_LO;
                default: fld_nx = FLD_LO;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_st  <= VS_LOW;
            fld_st <= FLD_LO;
        end else begin
            vs_st  <= vs_nx;
            fld_st <= fld_nx;
        end
    end

    // One flop per event drives the pin and the code bit together.
    always_comb begin
        vs_o    = (vs_st == VS_HIGH);
        vbit_o  = (vs_st == VS_HIGH);
        field_o = (fld_st == FLD_HI);
        fbit_o  = (fld_st == FLD_HI);
    end
endmodule

// File: rtl/fsa_chk.sv
module fsa_chk #(
    parameter int POS_W  = 10,
    parameter int RISE_H = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_stb_i,
    input logic             half_stb_i,
    input logic             vs_o,
    input logic             vbit_o,
    input logic             field_o,
    input logic             fbit_o,
    input logic [POS_W-1:0] pos_q,
    input logic [POS_W-1:0] vend_t,
    input logic [POS_W-1:0] ftog_t
);
    AST_VS_QUIET_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_stb_i || half_stb_i) |=> $stable(vs_o)); // R9
    AST_FLD_QUIET_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_stb_i || half_stb_i) |=> $stable(field_o)); // R9
    AST_VS_RISE_AT_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_o) |-> pos_q == POS_W'(RISE_H)); // R2
    AST_VS_FALL_AT_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vs_o) |-> pos_q == vend_t); // R3
    AST_FLD_FLIP_AT_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (field_o != $past(field_o)) |-> pos_q == ftog_t); // R7
    AST_VBIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        vbit_o == vs_o); // R10
    AST_FBIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_o == field_o); // R10
endmodule

bind field_sync_adj fsa_chk #(.POS_W(POS_W), .RISE_H(VS_RISE_H)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_stb_i (line_stb_i),
    .half_stb_i (half_stb_i),
    .vs_o       (vs_o),
    .vbit_o     (vbit_o),
    .field_o    (field_o),
    .fbit_o     (fbit_o),
    .pos_q      (pos_q),
    .vend_t     (vend_t),
    .ftog_t     (ftog_t)
);

// File: tb/field_sync_adj_tb.sv
module field_sync_adj_tb;
    localparam int FH    = 101;
    localparam int RISE  = 0;
    localparam int VREF  = 10;
    localparam int FREF  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_stb = 1'b0, half_stb = 1'b0, fstart = 1'b0, fodd = 1'b0;
    logic [4:0] v_cnt = '0, f_cnt = '0;
    logic v_adv = 0, v_xo = 0, v_xe = 0, v_ho = 0, v_he = 0;
    logic f_adv = 0, f_xo = 0, f_xe = 0;
    logic vs, fld, vbit, fbit;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string cur_req = "R1";

    // model state
    int m_pos = 0, m_vs = 0, m_fld = 0, m_odd = 0;
    int mv_cnt = 20, mv_adv = 0, mv_xo = 0, mv_xe = 0, mv_ho = 0, mv_he = 0;
    int mf_cnt = 3, mf_adv = 1, mf_xo = 0, mf_xe = 1;

    always #5 clk = ~clk;

    field_sync_adj #(.FIELD_HALVES(FH), .VS_RISE_H(RISE),
                     .VEND_REF_LINE(VREF), .FTOG_REF_LINE(FREF)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_stb_i(line_stb), .half_stb_i(half_stb),
        .field_start_i(fstart), .field_odd_i(fodd),
        .vend_cnt_i(v_cnt), .vend_adv_i(v_adv), .vend_xdly_odd_i(v_xo),
        .vend_xdly_even_i(v_xe), .vend_hadv_odd_i(v_ho), .vend_hadv_even_i(v_he),
        .ftog_cnt_i(f_cnt), .ftog_adv_i(f_adv), .ftog_xdly_odd_i(f_xo),
        .ftog_xdly_even_i(f_xe),
        .vs_o(vs), .field_o(fld), .vbit_o(vbit), .fbit_o(fbit)
    );

    function automatic int tgt(int ref_line, int cnt, int adv, int ext, int hadv);
        int v;
        v = 2 * ref_line + (adv != 0 ? -2 * cnt : 2 * cnt) + 2 * ext - hadv;
        return ((v % FH) + FH) % FH;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare(string req);
        chk(req, "vs", int'(vs), m_vs);
        chk(req, "field", int'(fld), m_fld);
        chk("R10", "vbit", int'(vbit), int'(vs));
        chk("R10", "fbit", int'(fbit), int'(fld));
    endtask

    task automatic strobe(bit ln, bit fs);
        int vt, ft;
        @(negedge clk);
        line_stb = ln; half_stb = !ln; fstart = fs && ln;
        if (fs && ln) begin
            m_pos = 0; m_odd = fodd;
            mv_cnt = v_cnt; mv_adv = v_adv; mv_xo = v_xo; mv_xe = v_xe;
            mv_ho = v_ho; mv_he = v_he;
            mf_cnt = f_cnt; mf_adv = f_adv; mf_xo = f_xo; mf_xe = f_xe;
        end else begin
            m_pos = (m_pos + 1) % FH;
        end
        vt = tgt(VREF, mv_cnt, mv_adv, m_odd != 0 ? mv_xo : mv_xe, m_odd != 0 ? mv_ho : mv_he);
        ft = tgt(FREF, mf_cnt, mf_adv, m_odd != 0 ? mf_xo : mf_xe, 0);
        if (m_pos == RISE) m_vs = 1;
        else if (m_pos == vt) m_vs = 0;
        if (m_pos == ft) m_fld = 1 - m_fld;
        @(negedge clk);
        line_stb = 0; half_stb = 0; fstart = 0;
        compare(cur_req);
        @(negedge clk);
        chk("R9", "vs idle", int'(vs), m_vs);
        chk("R9", "field idle", int'(fld), m_fld);
    endtask

    task automatic run_field(bit odd, bit mid_change);
        fodd = odd;
        for (int h = 0; h < FH; h++) begin
            if (mid_change && h == FH / 2) begin
                v_cnt = v_cnt + 5'd7; v_adv = ~v_adv; v_xo = ~v_xo; v_xe = ~v_xe;
                f_cnt = f_cnt + 5'd5; f_adv = ~f_adv; f_xo = ~f_xo; f_xe = ~f_xe;
                fodd = ~fodd;
            end
            strobe((h % 2) == 0, h == 0);
        end
    endtask

    task automatic run_pair();
        run_field(1'b1, 1'b0);
        run_field(1'b0, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        // R12: free run without field start uses reset settings
        cur_req = "R12";
        v_cnt = 5'd7; v_adv = 1; v_xo = 1; v_xe = 1; f_cnt = 5'd9; f_adv = 0; fodd = 1;
        for (int h = 1; h <= FH + 3; h++) strobe((h % 2) == 0, 1'b0);

        // R2: default-style setup, rise at fixed position
        cur_req = "R2";
        v_cnt = 5'd20; v_adv = 0; v_xo = 0; v_xe = 0; v_ho = 0; v_he = 0;
        f_cnt = 5'd3; f_adv = 1; f_xo = 0; f_xe = 1;
        run_pair();

        // R3: delay sweep
        cur_req = "R3";
        for (int c = 0; c < 32; c++) begin
            v_cnt = 5'(c); v_adv = 0; f_cnt = 5'(31 - c); f_adv = 0;
            run_pair();
        end

        // R4: advance sweep, wraps for large counts
        cur_req = "R4";
        for (int c = 0; c < 32; c++) begin
            v_cnt = 5'(c); v_adv = 1; f_cnt = 5'(c); f_adv = 1;
            run_pair();
        end

        // R5 and R6: per-field extra line and half-line combos
        for (int k = 0; k < 16; k++) begin
            cur_req = (k < 4) ? "R5" : "R6";
            v_xo = k[0]; v_xe = k[1]; v_ho = k[2]; v_he = k[3];
            v_cnt = 5'(3 + k); v_adv = k[1];
            run_pair();
        end
        v_xo = 0; v_xe = 0; v_ho = 0; v_he = 0;

        // R7: toggle with per-field extra lines, both directions
        cur_req = "R7";
        for (int k = 0; k < 8; k++) begin
            f_xo = k[0]; f_xe = k[1]; f_adv = k[2];
            f_cnt = 5'(k * 4 + 1);
            run_pair();
        end

        // R11: sync end lands on the rise position
        cur_req = "R11";
        v_cnt = 5'(VREF); v_adv = 1; v_xo = 0; v_xe = 0; v_ho = 0; v_he = 0;
        run_pair();

        // R8: mid-field changes take effect next field only
        cur_req = "R8";
        v_cnt = 5'd6; v_adv = 0; f_cnt = 5'd2; f_adv = 0; f_xo = 0; f_xe = 0;
        run_field(1'b1, 1'b1);
        run_field(1'b0, 1'b1);
        run_pair();

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule